// File: doc/BRIEF.md
# Carry-Skip Adder/Subtractor

This block is a purely combinational two's-complement adder/subtractor for datapath use. The operand width is cut into equal ripple groups. Each group forms per-bit generate and propagate terms and ripples its carry through its own bits. A bypass multiplexer hands the group's incoming carry straight to the next group whenever every bit of the group propagates. A long carry therefore crosses such groups in one mux delay each. The worst case is a carry born at bit 0 that ripples out of the first group, skips the middle groups and ripples up through the last one.

A single select line picks the operation. When it selects addition, the second operand and the external carry-in are used unchanged. When it selects subtraction, every bit of the second operand is inverted and the low-order carry is forced to one. The block returns the result word, the carry out of the top bit, and a signed-overflow flag.

Top module: `cskip_addsub`

## Requirements
- R1: With `sub_sel` = 0, `result` equals (op_a + op_b + carry_in) mod 2^WIDTH, and `carry_out` equals bit WIDTH of that sum.
- R2: With `sub_sel` = 1, `result` equals (op_a - op_b) mod 2^WIDTH, and `carry_out` is 1 exactly when op_a >= op_b as unsigned numbers (no borrow).
- R3: With `sub_sel` = 1, `carry_in` has no effect on `result`, `carry_out` or `ovf`.
- R4: With `sub_sel` = 0, `ovf` is 1 exactly when the signed sum op_a + op_b + carry_in lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: With `sub_sel` = 1, `ovf` is 1 exactly when the signed difference op_a - op_b lies outside that same range.
- R6: When op_a = ~op_b in add mode, so that every bit propagates, `result` is all ones with `carry_out` = 0 if carry_in = 0, and `result` is zero with `carry_out` = 1 if carry_in = 1.
- R7: A carry generated in a lower group reaches higher groups correctly, both when it passes through groups that propagate in every bit and when it is stopped or regenerated inside a group.
- R8: Any WIDTH that GROUP divides exactly gives the behaviour of R1 to R5. A WIDTH that GROUP does not divide is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend in subtract mode) |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Low-order carry for add mode; ignored when subtracting |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed two's-complement overflow |

## Verification
Random operands seldom make a whole group propagate, because each group of four bits does so with a probability of only 1/16. As a result, random stimulus almost never takes the bypass path with a live carry behind it. The stimulus therefore builds these patterns on purpose. It uses complementary operand pairs across the full word, and subtraction of equal operands, which propagates every bit once the subtrahend is inverted. It also walks a bit-0 carry into each group in turn while that group and the ones above propagate. A second instance with twelve bits in groups of three applies the same checks to a different group split.

// File: rtl/cskip_pkg.sv
`timescale 1ns/1ps
package cskip_pkg;
   localparam int unsigned DEF_WIDTH = 16;
   localparam int unsigned DEF_GROUP = 4;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } addsub_op_e;
endpackage

// File: rtl/cskip_cond.sv
`timescale 1ns/1ps
// Operand conditioning: selects the true or inverted subtrahend and the
// low-order carry for the chosen operation.
module cskip_cond
   import cskip_pkg::*;
#(
   parameter int unsigned WIDTH = DEF_WIDTH
) (
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] b_eff,
   output logic             c_low
);
   addsub_op_e op;

   always_comb begin
      op = addsub_op_e'(sub_sel);
      unique case (op)
         OP_SUB: begin
            b_eff = ~b_in;
            c_low = 1'b1;
         end
         default: begin
            b_eff = b_in;
            c_low = carry_in;
         end
      endcase
   end
endmodule

// File: rtl/cskip_group.sv
`timescale 1ns/1ps
// One ripple group with a bypass mux on its carry-out.
module cskip_group
   import cskip_pkg::*;
#(
   parameter int unsigned GROUP = DEF_GROUP
) (
   input  logic [GROUP-1:0] x,
   input  logic [GROUP-1:0] y,
   input  logic             cin,
   output logic [GROUP-1:0] sum,
   output logic             cout
);
   logic [GROUP-1:0] gen;
   logic [GROUP-1:0] prop;
   logic [GROUP:0]   chain;
   logic             grp_prop;
   logic [GROUP:0]   sum_chk;

   always_comb begin
      gen      = x & y;
      prop     = x ^ y;
      chain[0] = cin;
      for (int i = 0; i < int'(GROUP); i++) begin
         chain[i+1] = gen[i] | (prop[i] & chain[i]);
      end
      sum      = prop ^ chain[GROUP-1:0];
      grp_prop = &prop;
      cout     = grp_prop ? cin : chain[GROUP];
   end

   // Arithmetic cross-check of the group's gate-level result.
   always_comb begin
      sum_chk = {1'b0, x} + {1'b0, y} + {{GROUP{1'b0}}, cin};
      assert_group_sum_R1: assert final ({cout, sum} == sum_chk)
         else $error("group sum/carry disagrees with arithmetic");
      // R7: with every bit propagating, the ripple chain and the bypass agree.
      assert_bypass_R7: assert final (!grp_prop || (chain[GROUP] == cin))
         else $error("ripple carry differs from bypassed carry");
   end
endmodule

// File: rtl/cskip_addsub.sv
`timescale 1ns/1ps
// Single-level carry-skip adder/subtractor built from equal ripple groups.
module cskip_addsub
   import cskip_pkg::*;
#(
   parameter int unsigned WIDTH = DEF_WIDTH,
   parameter int unsigned GROUP = DEF_GROUP
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             ovf
);
   localparam int unsigned NGRP = (GROUP == 0) ? 1 : WIDTH / GROUP;
   localparam int unsigned MSB  = WIDTH - 1;

   // R8: elaboration-time shape checks.
   generate
      if (GROUP == 0 || (WIDTH % GROUP) != 0) begin : g_bad_split
         $error("WIDTH must be a non-zero multiple of GROUP");
      end
   endgenerate

   logic [WIDTH-1:0] b_eff;
   logic [NGRP:0]    gcarry;
   logic             c_low;

   cskip_cond #(.WIDTH(WIDTH)) u_cond (
      .b_in     (op_b),
      .sub_sel  (sub_sel),
      .carry_in (carry_in),
      .b_eff    (b_eff),
      .c_low    (c_low)
   );

   assign gcarry[0] = c_low;

   generate
      for (genvar gi = 0; gi < int'(NGRP); gi++) begin : g_grp
         cskip_group #(.GROUP(GROUP)) u_grp (
            .x    (op_a [gi*GROUP +: GROUP]),
            .y    (b_eff[gi*GROUP +: GROUP]),
            .cin  (gcarry[gi]),
            .sum  (result[gi*GROUP +: GROUP]),
            .cout (gcarry[gi+1])
         );
      end
   endgenerate

   // Carry into the MSB is recovered from the MSB sum and propagate terms.
   always_comb begin
      carry_out = gcarry[NGRP];
      ovf       = (op_a[MSB] ^ b_eff[MSB] ^ result[MSB]) ^ gcarry[NGRP];
   end

   always_comb begin
      // R3: subtraction forces the low carry and inverts the subtrahend.
      assert_sub_cond_R3: assert final (!sub_sel || (c_low && (b_eff == ~op_b)))
         else $error("subtract conditioning wrong");
      // R4/R5: sign rule on the conditioned operands.
      assert_ovf_sign_R4: assert final (ovf == ((op_a[MSB] == b_eff[MSB]) &&
                                               (result[MSB] != op_a[MSB])))
         else $error("overflow flag disagrees with sign rule");
      assert_add_total_R1: assert final (sub_sel ||
         ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})))
         else $error("add result wrong");
      assert_sub_total_R2: assert final (!sub_sel ||
         ({carry_out, result} == ({1'b0, op_a} + {1'b0, ~op_b} + {{WIDTH{1'b0}}, 1'b1})))
         else $error("subtract result wrong");
   end
endmodule

// File: tb/cskip_addsub_test.sv
`timescale 1ns/1ps
module cskip_addsub_test;
   localparam int W  = 16;
   localparam int WS = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   logic [W-1:0]  a, b, r;
   logic          sub, cin, co, ov;
   logic [WS-1:0] rs;
   logic          cos, ovs;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   cskip_addsub #(.WIDTH(W), .GROUP(4)) uut (
      .op_a(a), .op_b(b), .sub_sel(sub), .carry_in(cin),
      .result(r), .carry_out(co), .ovf(ov));

   cskip_addsub #(.WIDTH(WS), .GROUP(3)) uut_small (
      .op_a(a[WS-1:0]), .op_b(b[WS-1:0]), .sub_sel(sub), .carry_in(cin),
      .result(rs), .carry_out(cos), .ovf(ovs));

   // Behavioural reference: plain integer arithmetic.
   function automatic void model(input int w, input longint av, input longint bv,
                                 input bit s, input bit ci,
                                 output longint rr, output bit cc, output bit oo);
      longint mask = (longint'(1) << w) - 1;
      longint half = longint'(1) << (w - 1);
      longint t, sa, sb, sv;
      if (s) t = av + ((av - av) + mask - bv) + 1;
      else   t = av + bv + longint'(ci);
      rr = t & mask;
      cc = ((t >> w) & 1) != 0;
      sa = (av >= half) ? av - (mask + 1) : av;
      sb = (bv >= half) ? bv - (mask + 1) : bv;
      sv = s ? (sa - sb) : (sa + sb + longint'(ci));
      oo = (sv > half - 1) || (sv < -half);
   endfunction

   task automatic cmp(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h (a=%h b=%h sub=%0d cin=%0d)",
                  req, what, act, exp, a, b, sub, cin);
      end
   endtask

   task automatic apply(input string req, input logic [W-1:0] av, input logic [W-1:0] bv,
                        input bit s, input bit ci);
      longint er; bit ec, eo;
      @(posedge clk);
      a = av; b = bv; sub = s; cin = ci;
      @(negedge clk);
      model(W, longint'(av), longint'(bv), s, ci, er, ec, eo);
      cmp(req, "result", longint'(r), er);
      cmp(req, "carry_out", longint'(co), longint'(ec));
      cmp(req, "ovf", longint'(ov), longint'(eo));
      model(WS, longint'(av[WS-1:0]), longint'(bv[WS-1:0]), s, ci, er, ec, eo);
      cmp("R8", "small result", longint'(rs), er);
      cmp("R8", "small carry_out", longint'(cos), longint'(ec));
      cmp("R8", "small ovf", longint'(ovs), longint'(eo));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra, rb, r0, r1;
      logic c0v, c1v, o0v, o1v;
      a = '0; b = '0; sub = 1'b0; cin = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset-time state with all inputs low (R1).
      cmp("R1", "idle result", longint'(r), 0);
      cmp("R1", "idle carry", longint'(co), 0);
      cmp("R1", "idle ovf", longint'(ov), 0);
      rst = 1'b0;

      // R1: random additions
      for (int i = 0; i < 300; i++) apply("R1", W'($urandom), W'($urandom), 1'b0, 1'($urandom));
      // R2: random subtractions plus equal/less cases
      for (int i = 0; i < 300; i++) apply("R2", W'($urandom), W'($urandom), 1'b1, 1'($urandom));
      apply("R2", 16'h1234, 16'h1234, 1'b1, 1'b0);
      apply("R2", 16'h0003, 16'h0004, 1'b1, 1'b0);
      apply("R2", 16'hFFFF, 16'h0000, 1'b1, 1'b0);

      // R3: carry_in ignored when subtracting
      for (int i = 0; i < 20; i++) begin
         ra = W'($urandom); rb = W'($urandom);
         apply("R3", ra, rb, 1'b1, 1'b0);
         r0 = r; c0v = co; o0v = ov;
         apply("R3", ra, rb, 1'b1, 1'b1);
         r1 = r; c1v = co; o1v = ov;
         cmp("R3", "result vs cin", longint'(r1), longint'(r0));
         cmp("R3", "carry vs cin", longint'(c1v), longint'(c0v));
         cmp("R3", "ovf vs cin", longint'(o1v), longint'(o0v));
      end

      // R4: add overflow edges
      apply("R4", 16'h7FFF, 16'h0001, 1'b0, 1'b0);
      apply("R4", 16'h8000, 16'h8000, 1'b0, 1'b0);
      apply("R4", 16'h7FFF, 16'h0000, 1'b0, 1'b1);
      apply("R4", 16'h7FFE, 16'h0000, 1'b0, 1'b1);
      apply("R4", 16'hFFFF, 16'h8000, 1'b0, 1'b1);
      // R5: subtract overflow edges
      apply("R5", 16'h8000, 16'h0001, 1'b1, 1'b0);
      apply("R5", 16'h7FFF, 16'hFFFF, 1'b1, 1'b0);
      apply("R5", 16'h0000, 16'h8000, 1'b1, 1'b0);
      apply("R5", 16'hFFFF, 16'h8000, 1'b1, 1'b0);

      // R6: full-word propagate
      for (int i = 0; i < 40; i++) begin
         ra = W'($urandom);
         apply("R6", ra, ~ra, 1'b0, 1'b0);
         cmp("R6", "all ones", longint'(r), longint'(16'hFFFF));
         apply("R6", ra, ~ra, 1'b0, 1'b1);
         cmp("R6", "wrap to zero", longint'(r), 0);
         cmp("R6", "carry out", longint'(co), 1);
         apply("R6", ra, ra, 1'b1, 1'b0);
         cmp("R6", "equal difference", longint'(r), 0);
      end

      // R7: carry from bit 0 skipping through propagating groups
      for (int g = 1; g < 4; g++) begin
         ra = 16'hFFFF << (4 * g);
         apply("R7", ra | 16'h0001, 16'h000F, 1'b0, 1'b0);
         apply("R7", 16'h0001, 16'hFFFF, 1'b0, 1'b0);
         apply("R7", ra, 16'h0000, 1'b0, 1'b1);
         apply("R7", 16'h0F0F, 16'h00F1, 1'b0, 1'b0);
         apply("R7", 16'h00F0 | 16'h0008, 16'h0008, 1'b0, 1'b0);
      end

      // R8: small-instance boundaries
      apply("R8", 16'h0FFF, 16'h0001, 1'b0, 1'b0);
      apply("R8", 16'h07FF, 16'h0001, 1'b0, 1'b0);
      apply("R8", 16'h0800, 16'h0001, 1'b1, 1'b1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule